// File: doc/BRIEF.md
# Smart Card Character Transceiver

This block moves 8-bit characters over the single shared I/O line of an asynchronous IC-card link, one direction at a time. A character on the line is a start bit, eight data bits and a parity bit, each one elementary time unit (etu) long. The etu is set through a register as a number of half-etu clock counts. The line is open-drain. The block only ever pulls it low (state A) or lets it float high (state Z). The receiver samples each bit near its middle, timing from the falling edge of the start bit.

Both card conventions are covered by three independent settings: bit order (LSB or MSB first), inversion of the data bits, and the parity sense. Inversion acts on the eight data bits only. For the inverse convention, software therefore selects MSB first, inverted data and odd parity together. A transmit-end flag rises after a programmable guard interval and can raise an interrupt. A receive-full flag and a parity-error flag report each incoming character. An optional divided clock can be driven to the card.

Software drives the block through a 4-word register port. Writing the transmit word starts a character. Reading the receive word with the read strobe empties the receive buffer.

Top module: `sc_xcvr`

## Requirements
- R1: After reset the line is released (io_oe_o=0), the status word reads 1 (tend=1, full=0, perr=0), card_clk_o=0, and txi_o=0 and rxi_o=0.
- R2: Register map at addr_i: 0 is control, 1 is the half-etu length h (an etu lasts 2h clocks), 2 written starts a character and read gives status {bit2 perr, bit1 full, bit0 tend}, and 3 read gives the received byte. A read of address 3 with rd_en_i clears full and perr. Control bits are: 0 te, 1 re, 2 tie, 3 rie, 4 clk_oe, 5 msb_first, 6 inv_data, 7 odd_par, 8 tend_short.
- R3: A transmitted character is a start bit A followed by 8 data bits and then a parity bit, each 2h clocks long. The line is pulled low only for A and is released for Z. With msb_first=0 and inv_data=0, data bit 0 goes first and a 1 is sent as Z.
- R4: With msb_first=1, data bit 7 is sent first and is received first. The same order applies on receive.
- R5: inv_data=1 complements the eight data bits on transmit and on receive, and never touches the parity bit. The parity bit is chosen so that the count of Z states over the eight data bits plus parity is even when odd_par=0 and odd when odd_par=1.
- R6: A write to address 2 is accepted only when te=1 and tend=1. Acceptance clears tend. tend sets again 25h clocks (12.5 etu) after the accepting edge, or 22h clocks (11 etu) when tend_short=1. A write at any other time leaves the line, tend and the character in progress unchanged.
- R7: The receiver decodes a line character with the current settings and sets full. It sets perr when the parity rule of R5 fails. In direct settings, the line pattern A ZZAZZZAA Z decodes as 0x3B. In inverse settings, A ZZAAAAAA Z decodes as 0x3F.
- R8: With re=0, or while tend=0 (own transmission), nothing is received and full stays 0.
- R9: txi_o is high exactly when tie=1 and tend=1. rxi_o is high exactly when rie=1 and full=1.
- R10: With clk_oe=1, card_clk_o toggles every CARD_DIV clocks. With clk_oe=0 it is held low.
- R11: The line is released whenever no character is being sent, including the guard interval after the parity bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Register write strobe |
| rd_en_i | input | 1 | Register read strobe (clears receive flags at address 3) |
| addr_i | input | 2 | Register address |
| wdata_i | input | DW | Write data |
| rdata_o | output | DW | Read data for addr_i |
| io_i | input | 1 | Sensed level of the card I/O line |
| io_oe_o | output | 1 | 1 pulls the I/O line low |
| card_clk_o | output | 1 | Divided card clock |
| txi_o | output | 1 | Transmit-end interrupt request |
| rxi_o | output | 1 | Receive-full interrupt request |

## Verification
Several relations hold on every cycle and are asserted continuously. The line stays released while tend is high. The receiver stays idle during the block's own transmission. An accepted start write clears tend on the next cycle. The card clock sits low while it is disabled. Each interrupt request is accompanied by its flag. The rest can only be shown by bench scenarios with known answers: the exact bit pattern and parity on the line under each combination of order, inversion and parity sense, the two guard-interval lengths counted in clocks, the decoding of both initial-character patterns, the detection of a wrong parity bit, and the start writes that must be ignored.

// File: rtl/sc_pkg.sv
package sc_pkg;
  typedef enum logic [1:0] {
    ADR_CTRL = 2'd0,
    ADR_HALF = 2'd1,
    ADR_TXST = 2'd2,
    ADR_RXD  = 2'd3
  } sc_addr_e;

  typedef struct packed {
    logic tend_short;
    logic odd_par;
    logic inv_data;
    logic msb_first;
    logic clk_oe;
    logic rie;
    logic tie;
    logic re;
    logic te;
  } sc_ctrl_t;

  localparam int unsigned CHAR_W     = 8;
  localparam int unsigned FRAME_BITS = CHAR_W + 2;
  localparam int unsigned CTRL_W     = $bits(sc_ctrl_t);
  // guard end points in half-etu units from the start edge
  localparam int unsigned END_LONG   = 25;
  localparam int unsigned END_SHORT  = 22;

  function automatic logic [CHAR_W-1:0] bit_rev(input logic [CHAR_W-1:0] v);
    logic [CHAR_W-1:0] r;
    for (int i = 0; i < CHAR_W; i++) r[i] = v[CHAR_W-1-i];
    return r;
  endfunction
endpackage

// File: rtl/sc_tx.sv
module sc_tx
  import sc_pkg::*;
#(
  parameter int unsigned CW = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [CW-1:0]     half_i,
  input  logic              load_i,
  input  logic [CHAR_W-1:0] data_i,
  input  logic              msb_first_i,
  input  logic              inv_i,
  input  logic              odd_i,
  input  logic              short_i,
  output logic              tend_o,
  output logic              drive_low_o
);
  localparam int unsigned PH_W  = $clog2(END_LONG + 1);
  localparam int unsigned IDX_W = PH_W - 1;

  logic                  tend_q;
  logic                  short_q;
  logic [PH_W-1:0]       ph_q;
  logic [CW-1:0]         cnt_q;
  logic [FRAME_BITS-1:0] frame_q;

  logic [CHAR_W-1:0]     line_data;
  logic [CHAR_W-1:0]     ordered;
  logic                  par_bit;
  logic [PH_W-1:0]       last_ph;
  logic [IDX_W-1:0]      idx;

  assign line_data = data_i ^ {CHAR_W{inv_i}};
  assign ordered   = msb_first_i ? bit_rev(line_data) : line_data;
  assign par_bit   = (^line_data) ^ odd_i;
  assign last_ph   = short_q ? PH_W'(END_SHORT - 1) : PH_W'(END_LONG - 1);
  assign idx       = ph_q[PH_W-1:1];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      tend_q  <= 1'b1;
      short_q <= 1'b0;
      ph_q    <= '0;
      cnt_q   <= '0;
      frame_q <= '1;
    end else if (load_i && tend_q) begin
      tend_q  <= 1'b0;
      short_q <= short_i;
      ph_q    <= '0;
      cnt_q   <= '0;
      frame_q <= {par_bit, ordered, 1'b0};
    end else if (!tend_q) begin
      if (cnt_q == half_i - CW'(1)) begin
        cnt_q <= '0;
        if (ph_q == last_ph) tend_q <= 1'b1;
        else ph_q <= ph_q + PH_W'(1);
      end else begin
        cnt_q <= cnt_q + CW'(1);
      end
    end
  end

  always_comb begin
    drive_low_o = 1'b0;
    if (!tend_q && (idx < IDX_W'(FRAME_BITS))) drive_low_o = ~frame_q[idx];
  end

  assign tend_o = tend_q;
endmodule

// File: rtl/sc_rx.sv
module sc_rx
  import sc_pkg::*;
#(
  parameter int unsigned CW = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [CW-1:0]     half_i,
  input  logic              en_i,
  input  logic              line_i,
  input  logic              msb_first_i,
  input  logic              inv_i,
  input  logic              odd_i,
  output logic              active_o,
  output logic              done_o,
  output logic [CHAR_W-1:0] data_o,
  output logic              perr_o
);
  localparam int unsigned IDX_W = $clog2(FRAME_BITS + 1);

  logic [2:0]        sync_q;
  logic              act_q;
  logic [IDX_W-1:0]  idx_q;
  logic [CW:0]       cnt_q;
  logic [CHAR_W-1:0] raw_q;
  logic              done_q;
  logic [CHAR_W-1:0] data_q;
  logic              perr_q;

  logic              cur;
  logic              prev;
  logic [CW:0]       limit;
  logic [CHAR_W-1:0] decoded;

  assign cur     = sync_q[1];
  assign prev    = sync_q[2];
  // first wait is half an etu to land mid start bit, then whole etus
  assign limit   = (idx_q == '0) ? ({1'b0, half_i} - (CW+1)'(1))
                                 : ({half_i, 1'b0} - (CW+1)'(1));
  assign decoded = (msb_first_i ? bit_rev(raw_q) : raw_q) ^ {CHAR_W{inv_i}};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sync_q <= '1;
    else         sync_q <= {sync_q[1:0], line_i};
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      act_q  <= 1'b0;
      idx_q  <= '0;
      cnt_q  <= '0;
      raw_q  <= '0;
      done_q <= 1'b0;
      data_q <= '0;
      perr_q <= 1'b0;
    end else begin
      done_q <= 1'b0;
      if (!en_i) begin
        act_q <= 1'b0;
      end else if (!act_q) begin
        if (prev && !cur) begin
          act_q <= 1'b1;
          idx_q <= '0;
          cnt_q <= '0;
        end
      end else if (cnt_q == limit) begin
        cnt_q <= '0;
        idx_q <= idx_q + IDX_W'(1);
        if (idx_q == '0) begin
          if (cur) act_q <= 1'b0;  // start bit gone: glitch
        end else if (idx_q == IDX_W'(FRAME_BITS - 1)) begin
          act_q  <= 1'b0;
          done_q <= 1'b1;
          data_q <= decoded;
          perr_q <= ((^raw_q) ^ cur) != odd_i;
        end else begin
          raw_q <= {cur, raw_q[CHAR_W-1:1]};
        end
      end else begin
        cnt_q <= cnt_q + (CW+1)'(1);
      end
    end
  end

  assign active_o = act_q;
  assign done_o   = done_q;
  assign data_o   = data_q;
  assign perr_o   = perr_q;
endmodule

// File: rtl/sc_card_clk.sv
module sc_card_clk #(
  parameter int unsigned DIV = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic en_i,
  output logic clk_o
);
  localparam int unsigned CNT_W = (DIV > 1) ? $clog2(DIV) : 1;

  logic [CNT_W-1:0] cnt_q;
  logic             q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      q     <= 1'b0;
    end else if (!en_i) begin
      cnt_q <= '0;
      q     <= 1'b0;
    end else if (cnt_q == CNT_W'(DIV - 1)) begin
      cnt_q <= '0;
      q     <= ~q;
    end else begin
      cnt_q <= cnt_q + CNT_W'(1);
    end
  end

  assign clk_o = q;
endmodule

// File: rtl/sc_xcvr.sv
module sc_xcvr
  import sc_pkg::*;
#(
  parameter int unsigned DW       = 16,
  parameter int unsigned HALF_RST = 16,
  parameter int unsigned CARD_DIV = 2
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          wr_en_i,
  input  logic          rd_en_i,
  input  logic [1:0]    addr_i,
  input  logic [DW-1:0] wdata_i,
  output logic [DW-1:0] rdata_o,
  input  logic          io_i,
  output logic          io_oe_o,
  output logic          card_clk_o,
  output logic          txi_o,
  output logic          rxi_o
);
  sc_ctrl_t          ctrl_q;
  logic [DW-1:0]     half_q;
  logic [DW-1:0]     half_eff;
  logic [CHAR_W-1:0] rx_data_q;
  logic              full_q;
  logic              perr_q;

  logic              tx_load;
  logic              tend;
  logic              tx_drive;
  logic              rx_active;
  logic              rx_done;
  logic [CHAR_W-1:0] rx_data;
  logic              rx_perr;
  logic              rx_clear;

  assign half_eff = (half_q == '0) ? DW'(1) : half_q;
  assign tx_load  = wr_en_i && (addr_i == ADR_TXST) && ctrl_q.te;
  assign rx_clear = rd_en_i && (addr_i == ADR_RXD);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctrl_q <= '0;
      half_q <= DW'(HALF_RST);
    end else if (wr_en_i) begin
      if (addr_i == ADR_CTRL) ctrl_q <= sc_ctrl_t'(wdata_i[CTRL_W-1:0]);
      if (addr_i == ADR_HALF) half_q <= wdata_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rx_data_q <= '0;
      full_q    <= 1'b0;
      perr_q    <= 1'b0;
    end else if (rx_done) begin
      rx_data_q <= rx_data;
      full_q    <= 1'b1;
      perr_q    <= rx_perr;
    end else if (rx_clear) begin
      full_q <= 1'b0;
      perr_q <= 1'b0;
    end
  end

  sc_tx #(.CW(DW)) u_tx (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .half_i      (half_eff),
    .load_i      (tx_load),
    .data_i      (wdata_i[CHAR_W-1:0]),
    .msb_first_i (ctrl_q.msb_first),
    .inv_i       (ctrl_q.inv_data),
    .odd_i       (ctrl_q.odd_par),
    .short_i     (ctrl_q.tend_short),
    .tend_o      (tend),
    .drive_low_o (tx_drive)
  );

  sc_rx #(.CW(DW)) u_rx (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .half_i      (half_eff),
    .en_i        (ctrl_q.re && tend),
    .line_i      (io_i),
    .msb_first_i (ctrl_q.msb_first),
    .inv_i       (ctrl_q.inv_data),
    .odd_i       (ctrl_q.odd_par),
    .active_o    (rx_active),
    .done_o      (rx_done),
    .data_o      (rx_data),
    .perr_o      (rx_perr)
  );

  sc_card_clk #(.DIV(CARD_DIV)) u_cclk (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .en_i   (ctrl_q.clk_oe),
    .clk_o  (card_clk_o)
  );

  always_comb begin
    unique case (addr_i)
      ADR_CTRL: rdata_o = {{(DW-CTRL_W){1'b0}}, ctrl_q};
      ADR_HALF: rdata_o = half_q;
      ADR_TXST: rdata_o = {{(DW-3){1'b0}}, perr_q, full_q, tend};
      default:  rdata_o = {{(DW-CHAR_W){1'b0}}, rx_data_q};
    endcase
  end

  assign io_oe_o = tx_drive;
  assign txi_o   = ctrl_q.tie && tend;
  assign rxi_o   = ctrl_q.rie && full_q;
endmodule

// File: rtl/sc_xcvr_chk.sv
module sc_xcvr_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       wr_en_i,
  input logic [1:0] addr_i,
  input logic       te,
  input logic       tend,
  input logic       rx_active,
  input logic       clk_oe,
  input logic       card_clk_o,
  input logic       io_oe_o,
  input logic       txi_o,
  input logic       rxi_o,
  input logic       full
);
  AST_IDLE_RELEASE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tend |-> !io_oe_o);  // R11

  AST_NO_RX_WHILE_TX: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!tend && $past(!tend)) |-> !rx_active);  // R8

  AST_TEND_CLEAR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && addr_i == 2'd2 && te && tend) |=> !tend);  // R6

  AST_CLK_HELD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !clk_oe |=> !card_clk_o);  // R10

  AST_TXI_FLAG: assert property (@(posedge clk_i) disable iff (!rst_ni)
    txi_o |-> tend);  // R9

  AST_RXI_FLAG: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rxi_o |-> full);  // R9
endmodule

bind sc_xcvr sc_xcvr_chk u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .wr_en_i    (wr_en_i),
  .addr_i     (addr_i),
  .te         (ctrl_q.te),
  .tend       (tend),
  .rx_active  (rx_active),
  .clk_oe     (ctrl_q.clk_oe),
  .card_clk_o (card_clk_o),
  .io_oe_o    (io_oe_o),
  .txi_o      (txi_o),
  .rxi_o      (rxi_o),
  .full       (full_q)
);

// File: tb/sc_xcvr_tb.sv
module sc_xcvr_tb;
  localparam int unsigned CLK_PERIOD = 10;
  localparam int unsigned DW         = 16;
  localparam int unsigned H          = 4;
  localparam int unsigned CDIV       = 3;
  localparam int unsigned NVEC       = 7;

  // {odd_par, inv_data, msb_first} , data , line pattern (bit i = i-th bit on line, 1 = Z)
  localparam logic [20:0] VEC [NVEC] = '{
    {3'b000, 8'h3B, 10'b1001110110},
    {3'b111, 8'h3F, 10'b1000000110},
    {3'b000, 8'h00, 10'b0000000000},
    {3'b000, 8'hA5, 10'b0101001010},
    {3'b001, 8'h01, 10'b1100000000},
    {3'b010, 8'h0F, 10'b0111100000},
    {3'b100, 8'hFF, 10'b1111111110}
  };

  logic          clk_i = 1'b0;
  logic          rst_ni = 1'b0;
  logic          wr_en_i = 1'b0;
  logic          rd_en_i = 1'b0;
  logic [1:0]    addr_i = 2'd2;
  logic [DW-1:0] wdata_i = '0;
  logic [DW-1:0] rdata_o;
  logic          io_oe_o;
  logic          card_clk_o;
  logic          txi_o;
  logic          rxi_o;
  logic          card_low = 1'b0;
  logic          line;
  int            n_chk = 0;
  int            n_fail = 0;
  bit            finished = 1'b0;

  assign line = ~(io_oe_o | card_low);

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  sc_xcvr #(.DW(DW), .HALF_RST(16), .CARD_DIV(CDIV)) u_dut (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .wr_en_i    (wr_en_i),
    .rd_en_i    (rd_en_i),
    .addr_i     (addr_i),
    .wdata_i    (wdata_i),
    .rdata_o    (rdata_o),
    .io_i       (line),
    .io_oe_o    (io_oe_o),
    .card_clk_o (card_clk_o),
    .txi_o      (txi_o),
    .rxi_o      (rxi_o)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [DW-1:0] d);
    addr_i = a; wdata_i = d; wr_en_i = 1'b1;
    @(posedge clk_i);
    @(negedge clk_i);
    wr_en_i = 1'b0; addr_i = 2'd2;
  endtask

  task automatic status(output logic [2:0] s);
    addr_i = 2'd2; #1; s = rdata_o[2:0];
  endtask

  task automatic rd_rx(output logic [7:0] d);
    addr_i = 2'd3; #1; d = rdata_o[7:0];
    rd_en_i = 1'b1;
    @(posedge clk_i);
    @(negedge clk_i);
    rd_en_i = 1'b0; addr_i = 2'd2;
  endtask

  task automatic card_send(input logic [9:0] pat);
    for (int i = 0; i < 10; i++) begin
      card_low = ~pat[i];
      repeat (2*H) @(negedge clk_i);
    end
    card_low = 1'b0;
    repeat (4*H) @(negedge clk_i);
  endtask

  task automatic summary();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
  endtask

  initial begin
    repeat (150000) @(posedge clk_i);
    if (!finished) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog expired");
      summary();
      $finish;
    end
  end

  initial begin
    logic [2:0] s;
    logic [7:0] d;
    logic [9:0] got;
    int         tog;
    logic       prev;

    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);

    // R1 reset state
    status(s);
    chk("R1 status", s, 3'b001);
    chk("R1 line released", io_oe_o, 0);
    chk("R1 card clock", card_clk_o, 0);
    chk("R1 irqs", {txi_o, rxi_o}, 2'b00);

    // R2 half-etu register
    wr(2'd1, DW'(H));
    addr_i = 2'd1; #1;
    chk("R2 half readback", rdata_o, DW'(H));
    addr_i = 2'd2;

    // table: transmit pattern then receive same pattern (R3 R4 R5 R7)
    for (int v = 0; v < NVEC; v++) begin
      logic [2:0] cfg;
      logic [7:0] dat;
      logic [9:0] pat;
      {cfg, dat, pat} = VEC[v];
      wr(2'd0, DW'(16'h0003 | (DW'(cfg[0]) << 5) | (DW'(cfg[1]) << 6) | (DW'(cfg[2]) << 7)));
      wr(2'd2, DW'(dat));
      for (int i = 0; i < 10; i++) begin
        repeat ((i == 0) ? H : 2*H) @(negedge clk_i);
        got[i] = line;
      end
      chk($sformatf("R3 R4 R5 line pattern vec%0d", v), got, pat);
      repeat (6*H) @(negedge clk_i);
      status(s);
      chk($sformatf("R6 R8 R11 after tx vec%0d", v), {s, io_oe_o}, 4'b0010);
      card_send(pat);
      status(s);
      chk($sformatf("R7 rx status vec%0d", v), s, 3'b011);
      rd_rx(d);
      chk($sformatf("R7 rx data vec%0d", v), d, dat);
      status(s);
      chk($sformatf("R2 rx clear vec%0d", v), s, 3'b001);
    end

    // R6 default guard: tend at 25h clocks
    wr(2'd0, DW'(16'h0001));
    wr(2'd2, DW'(8'h55));
    repeat (25*H - 1) @(negedge clk_i);
    status(s);
    chk("R6 tend low before 12.5 etu", s[0], 0);
    @(negedge clk_i);
    status(s);
    chk("R6 tend at 12.5 etu", s[0], 1);

    // R6 short guard: tend at 22h clocks
    wr(2'd0, DW'(16'h0101));
    wr(2'd2, DW'(8'h55));
    repeat (22*H - 1) @(negedge clk_i);
    status(s);
    chk("R6 short tend low before 11 etu", s[0], 0);
    @(negedge clk_i);
    status(s);
    chk("R6 short tend at 11 etu", s[0], 1);

    // R6 write while busy ignored
    wr(2'd0, DW'(16'h0001));
    wr(2'd2, DW'(8'h00));
    repeat (H) @(negedge clk_i);
    wr(2'd2, DW'(8'hFF));
    repeat (2*H - 1) @(negedge clk_i);
    chk("R6 busy write ignored bit0", line, 0);
    repeat (22*H - 1) @(negedge clk_i);
    status(s);
    chk("R6 busy write ignored tend", s[0], 0);
    @(negedge clk_i);
    status(s);
    chk("R6 original char ends on time", s[0], 1);

    // R6 te=0 write ignored
    wr(2'd0, DW'(16'h0002));
    wr(2'd2, DW'(8'h00));
    repeat (H) @(negedge clk_i);
    status(s);
    chk("R6 te off no tx", {line, s}, 4'b1001);

    // R7 parity error
    wr(2'd0, DW'(16'h0002));
    card_send(10'b0001110110);
    status(s);
    chk("R7 parity error flagged", s, 3'b111);
    rd_rx(d);
    chk("R7 data despite perr", d, 8'h3B);

    // R8 receiver disabled
    wr(2'd0, DW'(16'h0001));
    card_send(10'b1001110110);
    status(s);
    chk("R8 re off nothing received", s, 3'b001);

    // R9 interrupts
    wr(2'd0, DW'(16'h000E));
    chk("R9 txi with tie and tend", {txi_o, rxi_o}, 2'b10);
    card_send(10'b1001110110);
    chk("R9 rxi on full", {txi_o, rxi_o}, 2'b11);
    rd_rx(d);
    chk("R9 rxi cleared", rxi_o, 0);

    // R10 card clock
    wr(2'd0, DW'(16'h0010));
    tog = 0; prev = card_clk_o;
    for (int i = 0; i < 8*CDIV; i++) begin
      @(negedge clk_i);
      if (card_clk_o != prev) tog++;
      prev = card_clk_o;
    end
    chk("R10 toggles", tog, 8);
    wr(2'd0, DW'(16'h0000));
    tog = 0;
    for (int i = 0; i < 4*CDIV; i++) begin
      @(negedge clk_i);
      if (card_clk_o) tog++;
    end
    chk("R10 held low", tog, 0);

    finished = 1'b1;
    summary();
    $finish;
  end
endmodule